// File: doc/BRIEF.md
# Rectangular Texture Swizzle Address Generator

This block turns a texel coordinate into the byte address of that texel in a swizzled texture. The texture is stored in Morton order, which means the x and y bits are interleaved. Its width and height are both powers of two, and they may differ. A non-square texture is laid out as a linear run of square Morton tiles. The tile side equals the smaller of the two dimensions, and the tiles follow one another along the longer dimension. Inside a tile the low coordinate bits are interleaved. The tile number, taken from the high coordinate bits, selects which tile-sized block of texels the index falls in.

A copy engine or a texture loader presents x, y, the log2 of the width and of the height, a base byte offset and a bytes-per-texel code on a valid/ready input. Two cycles after acceptance the block returns the byte address on a valid/ready output. It also returns a flag that is set when that address is not a multiple of 64 bytes, so a copy-region start can be rejected. The pipeline has two stages: the texel index is formed in the first and the byte address in the second.

Top module: `swz_addr_gen`

## Requirements
- R1: The square tile side is 2^min(log2 width, log2 height). Only the coordinate bits below that side are interleaved.
- R2: Inside a tile, low x bit i goes to texel-index bit 2i and low y bit i goes to texel-index bit 2i+1.
- R3: The high bits, (x|y) with the low tile-side bits cleared, are multiplied by the tile side and added to the interleaved low part to give the texel index. So for every tile after the first, the index starts at tile number times side squared.
- R4: For a square texture, the texel index equals a full interleave of all 12 bits of x and y.
- R5: The byte address is base + (texel index << code). Code values 0 to 4 select 1, 2, 4, 8 or 16 bytes per texel. Codes 5 to 7 act as code 4. The address is 32 bits and wraps modulo 2^32.
- R6: out_misaligned is 1 exactly when out_addr[5:0] is not zero, meaning the address is not a multiple of 64.
- R7: A request accepted at a rising edge appears on the output with out_valid high after the next rising edge. out_valid stays low in between.
- R8: While out_valid is high and out_ready is low, out_valid, out_addr and out_misaligned hold their values.
- R9: After reset, out_valid is 0 and in_ready is 1. When both stages hold data and out_ready is low, in_ready is 0. No request is lost under stall.
- R10: The block accepts 12-bit coordinates and log2 dimensions up to 12 (4096 texels per side), giving a texel index of up to 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_x | input | 12 | Texel x coordinate |
| in_y | input | 12 | Texel y coordinate |
| in_log2_w | input | 4 | log2 of texture width |
| in_log2_h | input | 4 | log2 of texture height |
| in_base | input | 32 | Base byte offset of the texture |
| in_bpt_code | input | 3 | log2 of bytes per texel (0..4, higher acts as 4) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken |
| out_addr | output | 32 | Byte address of the texel |
| out_misaligned | output | 1 | Address not a multiple of 64 bytes |

## Verification
The address function is tried on textures wider than tall (2048x1024, 4096x1024), taller than wide (1024x4096), square (1024, 4096, 1x1) and small (16x2). Coordinates lie both in the first tile and in later tiles. Later-tile points separate the tile-concatenation rule from a plain full interleave, and they separate the use of the smaller side from the use of the larger. Square points show that the two rules agree when the sides are equal. Tile-start points with wide texels, and odd base offsets, drive the 64-byte flag both ways. Back-to-back requests under a held out_ready exercise the hold and the back-pressure.

// File: rtl/swz_pkg.sv
// Shared sizes for the swizzle address generator.
// Assumes texture sides are powers of two, at most 2^COORD_W.
package swz_pkg;
    localparam int COORD_W   = 12;            // coordinate width, 4096 per side
    localparam int LOG_W     = 4;             // width of log2 dimension fields
    localparam int IDX_W     = 2 * COORD_W;   // texel index width
    localparam int ADDR_W    = 32;            // byte address width
    localparam int BPT_W     = 3;             // bytes-per-texel code width
    localparam int MAX_SHIFT = 4;             // 16 bytes per texel at most
    localparam int ALIGN_LOG = 6;             // 64-byte alignment for copy starts
endpackage

// File: rtl/swz_interleave.sv
// Morton interleave of two coordinates.
// x bit i lands on output bit 2i, y bit i on output bit 2i+1.
// Purely combinational; the caller masks off bits that must not take part.
module swz_interleave #(
    parameter int COORD_W = swz_pkg::COORD_W,
    localparam int OUT_W  = 2 * COORD_W
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    output logic [OUT_W-1:0]   code_o
);
    // One pair of output bits per coordinate bit.
    for (genvar i = 0; i < COORD_W; i++) begin : g_bit
        assign code_o[2*i]   = x_i[i];
        assign code_o[2*i+1] = y_i[i];
    end
endmodule

// File: rtl/swz_tile_index.sv
// Texel index of a coordinate in a texture made of square Morton tiles.
// Tile side is 2^min(log_w, log_h). Low coordinate bits are interleaved,
// and the high bits (x|y above the tile) times the side give the tile base.
// Assumes coordinates lie inside the texture; log values above COORD_W clamp.
module swz_tile_index #(
    parameter int COORD_W = swz_pkg::COORD_W,
    parameter int LOG_W   = swz_pkg::LOG_W,
    localparam int IDX_W  = 2 * COORD_W
) (
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  logic [LOG_W-1:0]   log_w_i,
    input  logic [LOG_W-1:0]   log_h_i,
    output logic [IDX_W-1:0]   idx_o
);
    logic [LOG_W-1:0]   side_log;
    logic [COORD_W-1:0] low_mask;
    logic [COORD_W-1:0] x_low;
    logic [COORD_W-1:0] y_low;
    logic [COORD_W-1:0] high_bits;
    logic [IDX_W-1:0]   tile_base;
    logic [IDX_W-1:0]   morton;

    // Tile side exponent: smaller dimension, clamped to the coordinate width.
    always_comb begin
        side_log = (log_w_i < log_h_i) ? log_w_i : log_h_i;
        if (side_log > LOG_W'(COORD_W))
            side_log = LOG_W'(COORD_W);
    end

    // Split coordinates into the in-tile part and the tile-selecting part.
    always_comb begin
        low_mask  = ~({COORD_W{1'b1}} << side_log);
        x_low     = x_i & low_mask;
        y_low     = y_i & low_mask;
        high_bits = (x_i | y_i) & ~low_mask;
        tile_base = {{COORD_W{1'b0}}, high_bits} << side_log;
    end

    swz_interleave #(.COORD_W(COORD_W)) u_interleave (
        .x_i    (x_low),
        .y_i    (y_low),
        .code_o (morton)
    );

    // Tile base occupies bits at or above 2*side_log, Morton part below.
    assign idx_o = tile_base | morton;
endmodule

// File: rtl/swz_byte_addr.sv
// Byte address from base, texel index and bytes-per-texel code,
// plus the copy-start alignment check.
// Codes above MAX_SHIFT act as MAX_SHIFT. Address wraps at ADDR_W bits.
module swz_byte_addr #(
    parameter int IDX_W     = swz_pkg::IDX_W,
    parameter int ADDR_W    = swz_pkg::ADDR_W,
    parameter int BPT_W     = swz_pkg::BPT_W,
    parameter int MAX_SHIFT = swz_pkg::MAX_SHIFT,
    parameter int ALIGN_LOG = swz_pkg::ALIGN_LOG
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BPT_W-1:0]  code_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              misaligned_o
);
    logic [BPT_W-1:0]  shamt;
    logic [ADDR_W-1:0] offset;

    // Clamp the element size code to the largest supported texel.
    always_comb begin
        shamt = (code_i > BPT_W'(MAX_SHIFT)) ? BPT_W'(MAX_SHIFT) : code_i;
    end

    // Scale index to bytes and add the base.
    always_comb begin
        offset = {{(ADDR_W-IDX_W){1'b0}}, idx_i} << shamt;
        addr_o = base_i + offset;
    end

    // Any set bit below the alignment boundary flags the address.
    assign misaligned_o = |addr_o[ALIGN_LOG-1:0];
endmodule

// File: rtl/swz_addr_gen.sv
// Top: two-stage valid/ready pipeline around the swizzle address logic.
// Stage 1 registers the texel index with base and size code; stage 2
// registers the byte address and the alignment flag. Each stage moves
// on when the next one is empty or is being emptied. Output holds while
// out_ready is low. Synchronous active-low reset clears only valid bits.
module swz_addr_gen #(
    parameter int COORD_W   = swz_pkg::COORD_W,
    parameter int LOG_W     = swz_pkg::LOG_W,
    parameter int ADDR_W    = swz_pkg::ADDR_W,
    parameter int BPT_W     = swz_pkg::BPT_W,
    parameter int MAX_SHIFT = swz_pkg::MAX_SHIFT,
    parameter int ALIGN_LOG = swz_pkg::ALIGN_LOG,
    localparam int IDX_W    = 2 * COORD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic [LOG_W-1:0]   in_log2_w,
    input  logic [LOG_W-1:0]   in_log2_h,
    input  logic [ADDR_W-1:0]  in_base,
    input  logic [BPT_W-1:0]   in_bpt_code,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [ADDR_W-1:0]  out_addr,
    output logic               out_misaligned
);
    logic              s1_valid;
    logic [IDX_W-1:0]  s1_idx;
    logic [ADDR_W-1:0] s1_base;
    logic [BPT_W-1:0]  s1_code;
    logic              s2_valid;
    logic [ADDR_W-1:0] s2_addr;
    logic              s2_mis;
    logic              adv2;
    logic              adv1;
    logic [IDX_W-1:0]  idx_next;
    logic [ADDR_W-1:0] addr_next;
    logic              mis_next;

    // Stage enables: a stage loads when it is empty or its content moves on.
    always_comb begin
        adv2 = !s2_valid || out_ready;
        adv1 = !s1_valid || adv2;
    end

    assign in_ready = adv1;

    swz_tile_index #(.COORD_W(COORD_W), .LOG_W(LOG_W)) u_index (
        .x_i     (in_x),
        .y_i     (in_y),
        .log_w_i (in_log2_w),
        .log_h_i (in_log2_h),
        .idx_o   (idx_next)
    );

    // Stage 1 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s1_valid <= 1'b0;
        else if (adv1)
            s1_valid <= in_valid;
    end

    // Stage 1 data: texel index and what stage 2 needs.
    always_ff @(posedge clk) begin
        if (adv1 && in_valid) begin
            s1_idx  <= idx_next;
            s1_base <= in_base;
            s1_code <= in_bpt_code;
        end
    end

    swz_byte_addr #(
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W),
        .BPT_W     (BPT_W),
        .MAX_SHIFT (MAX_SHIFT),
        .ALIGN_LOG (ALIGN_LOG)
    ) u_addr (
        .base_i       (s1_base),
        .idx_i        (s1_idx),
        .code_i       (s1_code),
        .addr_o       (addr_next),
        .misaligned_o (mis_next)
    );

    // Stage 2 valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            s2_valid <= 1'b0;
        else if (adv2)
            s2_valid <= s1_valid;
    end

    // Stage 2 data: byte address and alignment flag.
    always_ff @(posedge clk) begin
        if (adv2 && s1_valid) begin
            s2_addr <= addr_next;
            s2_mis  <= mis_next;
        end
    end

    assign out_valid      = s2_valid;
    assign out_addr       = s2_addr;
    assign out_misaligned = s2_mis;
endmodule

// File: rtl/swz_addr_gen_chk.sv
// Protocol and flag checks for swz_addr_gen, attached by bind.
module swz_addr_gen_chk #(
    parameter int ADDR_W    = swz_pkg::ADDR_W,
    parameter int ALIGN_LOG = swz_pkg::ALIGN_LOG
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_misaligned,
    input logic              s1_valid
);
    // Stalled output keeps its value.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_misaligned)));

    // Alignment flag agrees with the presented address.
    assert_align_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_misaligned == (out_addr[ALIGN_LOG-1:0] != '0)));

    // Empty output stage always leaves room for a request.
    assert_ready_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // Full pipeline under stall pushes back.
    assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && out_valid && !out_ready) |-> !in_ready);

    // Output appears only after stage 1 held data.
    assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(s1_valid));
endmodule

bind swz_addr_gen swz_addr_gen_chk #(.ADDR_W(ADDR_W), .ALIGN_LOG(ALIGN_LOG)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_addr       (out_addr),
    .out_misaligned (out_misaligned),
    .s1_valid       (s1_valid)
);

// File: tb/swz_addr_gen_tb_top.sv
module swz_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [11:0] in_x = '0;
    logic [11:0] in_y = '0;
    logic [3:0]  in_log2_w = '0;
    logic [3:0]  in_log2_h = '0;
    logic [31:0] in_base = '0;
    logic [2:0]  in_bpt_code = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_addr;
    logic        out_misaligned;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;  // 50 MHz

    swz_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_log2_w(in_log2_w), .in_log2_h(in_log2_h),
        .in_base(in_base), .in_bpt_code(in_bpt_code), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_misaligned(out_misaligned)
    );

    // Vector: x[66:55] y[54:43] log_w[42:39] log_h[38:35] code[34:32] base[31:0]
    localparam int NV = 10;
    localparam logic [66:0] VEC [NV] = '{
        {12'd1500, 12'd700,  4'd11, 4'd10, 3'd2, 32'h0000_0000},
        {12'd1023, 12'd1023, 4'd11, 4'd10, 3'd0, 32'h0000_1000},
        {12'd3000, 12'd5,    4'd12, 4'd10, 3'd2, 32'h0010_0000},
        {12'd1024, 12'd0,    4'd12, 4'd10, 3'd4, 32'h0000_0000},
        {12'd17,   12'd2100, 4'd10, 4'd12, 3'd3, 32'h0000_0040},
        {12'd0,    12'd3072, 4'd10, 4'd12, 3'd0, 32'h0000_0000},
        {12'd513,  12'd770,  4'd10, 4'd10, 3'd1, 32'h0000_0020},
        {12'd4095, 12'd4095, 4'd12, 4'd12, 3'd2, 32'h0000_0000},
        {12'd9,    12'd1,    4'd4,  4'd1,  3'd0, 32'h0000_0003},
        {12'd0,    12'd0,    4'd0,  4'd0,  3'd4, 32'h0000_0080}
    };

    // Reference: tile number times side squared plus in-tile Morton code.
    function automatic logic [31:0] ref_addr(int x, int y, int lw, int lh, int code, logic [31:0] base);
        int ls = (lw < lh) ? lw : lh;
        int sh = (code > 4) ? 4 : code;
        longint morton = 0;
        longint tile;
        longint idx;
        for (int i = 0; i < ls; i++) begin
            morton += longint'((x >> i) & 1) << (2 * i);
            morton += longint'((y >> i) & 1) << (2 * i + 1);
        end
        tile = longint'((x >> ls) | (y >> ls));
        idx  = tile * (longint'(1) << (2 * ls)) + morton;
        return base + 32'(idx << sh);
    endfunction

    // Plain interleave of all 12 bits.
    function automatic logic [23:0] full_interleave(int x, int y);
        logic [23:0] r = '0;
        for (int i = 0; i < 12; i++) begin
            r[2*i]   = 1'((x >> i) & 1);
            r[2*i+1] = 1'((y >> i) & 1);
        end
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic drive(logic [66:0] v);
        in_x        = v[66:55];
        in_y        = v[54:43];
        in_log2_w   = v[42:39];
        in_log2_h   = v[38:35];
        in_bpt_code = v[34:32];
        in_base     = v[31:0];
    endtask

    function automatic logic [31:0] vec_ref(logic [66:0] v);
        return ref_addr(int'(v[66:55]), int'(v[54:43]), int'(v[42:39]),
                        int'(v[38:35]), int'(v[34:32]), v[31:0]);
    endfunction

    // Send one request with out_ready high; check latency, address, flag.
    task automatic send_check(logic [66:0] v, logic [31:0] exp, string req);
        @(negedge clk);
        drive(v);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R7 no early output", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R7 output valid", 32'(out_valid), 32'd1);
        check(req, out_addr, exp);
        check("R6 alignment flag", 32'(out_misaligned), 32'(exp[5:0] != 6'd0));
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    initial begin
        logic [66:0] a, b, c, sq;
        repeat (3) @(negedge clk);
        // Reset state (R9).
        check("R9 reset out_valid", 32'(out_valid), 32'd0);
        check("R9 reset in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;

        // Table walk: R1 R2 R3 R5 R10 across shapes, tiles and sizes.
        for (int k = 0; k < NV; k++)
            send_check(VEC[k], vec_ref(VEC[k]), "R1/R2/R3/R5/R10 table address");

        // R4: square texture matches a full interleave.
        sq = {12'd2730, 12'd1365, 4'd12, 4'd12, 3'd0, 32'h0};
        send_check(sq, {8'h0, full_interleave(2730, 1365)}, "R4 square full interleave");

        // R3: second tile of a 2048x1024 texture starts at side squared.
        send_check({12'd1024, 12'd0, 4'd11, 4'd10, 3'd0, 32'h0}, 32'h0010_0000, "R3 second tile start");

        // R2: x bit 1 -> bit 2, y bit 0 -> bit 1.
        send_check({12'd2, 12'd1, 4'd3, 4'd3, 3'd0, 32'h0}, 32'h0000_0006, "R2 bit placement");

        // R5: codes above 4 act as 16 bytes per texel.
        send_check({12'd3, 12'd0, 4'd2, 4'd2, 3'd7, 32'h0}, 32'd80, "R5 code clamp");

        // R6: aligned start with odd base flags misalignment.
        send_check({12'd0, 12'd0, 4'd5, 4'd5, 3'd4, 32'h0000_0011}, 32'h11, "R6 misaligned base");

        // R8/R9: stall with three requests in flight.
        a = VEC[0]; b = VEC[2]; c = VEC[4];
        @(negedge clk);
        out_ready = 1'b0;
        drive(a); in_valid = 1'b1;
        @(negedge clk);
        drive(b);
        @(negedge clk);
        drive(c);
        check("R9 backpressure in_ready", 32'(in_ready), 32'd0);
        check("R8 stalled output", out_addr, vec_ref(a));
        repeat (3) @(negedge clk);
        check("R8 held output", out_addr, vec_ref(a));
        check("R8 held valid", 32'(out_valid), 32'd1);
        check("R9 still blocked", 32'(in_ready), 32'd0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 second item after release", out_addr, vec_ref(b));
        @(negedge clk);
        check("R9 third item not lost", out_addr, vec_ref(c));
        check("R9 third item valid", 32'(out_valid), 32'd1);
        @(negedge clk);
        check("R9 drained", 32'(out_valid), 32'd0);

        finish_run();
    end
endmodule